// File: doc/BRIEF.md
# Serial Game Controller Reader

This block gives a processor a bit-serial view of two game controllers that each report sixteen buttons as a parallel word. Software writes a strobe register. When bit 0 of that write goes from clear to set, the block snapshots both button words and rewinds both read positions. Once the strobe is written back to 0, each read of a port's data register returns one button bit, starting with the most significant. After all sixteen bits have been read, further reads return a fixed 1.

While the strobe is held high, a read does not move the position. Port 1 then returns 0. Port 2 returns 0, or the value 2 when a multi-player adapter is reported as present; the adapter can only sit on port 2. A separate path copies both button words into two read-only parallel registers on each frame tick, but only while the automatic-read enable is set.

Top module: `pad_serial_reader`

## Requirements
- R1: After reset, both data outputs and both frame registers are 0.
- R2: A strobe write with bit 0 set, made while the strobe latch is clear, captures both button words and resets both read positions to 0.
- R3: A strobe write with bit 0 set, made while the latch is already set, neither recaptures the buttons nor rewinds the positions.
- R4: While the strobe latch is set, a port 1 read returns 0 and does not advance the read position.
- R5: While the strobe latch is set, a port 2 read returns 2 if the adapter flag is high and 0 otherwise, and does not advance the read position.
- R6: With the latch clear, successive reads of a port return captured bit 15 first, then bit 14 and so on down to bit 0. The bit is placed in data bit 0 and data bits 7..1 are 0.
- R7: Once a port has returned sixteen bits, every later read of that port returns the value 1 until the next capture.
- R8: A read pulse updates that port's data output at the next clock edge, and the output holds its value until the next read of that port.
- R9: The two ports keep separate read positions, so reading one port does not advance the other.
- R10: On a frame tick with the automatic-read enable high, both frame registers load the current button words. At any other time they keep their value.
- R11: With the latch clear, the adapter flag has no effect on port 2 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad1_buttons | input | 16 | Live button word, controller 1 |
| pad2_buttons | input | 16 | Live button word, controller 2 |
| adapter_present | input | 1 | Multi-player adapter detected on port 2 |
| strobe_we | input | 1 | Strobe register write pulse |
| strobe_wdata | input | 8 | Strobe write data; bit 0 is the strobe |
| pad1_rd | input | 1 | Read pulse, port 1 data register |
| pad2_rd | input | 1 | Read pulse, port 2 data register |
| pad1_q | output | 8 | Port 1 read result |
| pad2_q | output | 8 | Port 2 read result |
| auto_read_en | input | 1 | Automatic per-frame capture enable |
| frame_tick | input | 1 | One pulse per frame |
| pad1_frame | output | 16 | Frame-captured buttons, controller 1 |
| pad2_frame | output | 16 | Frame-captured buttons, controller 2 |

## Verification
The assertions check several things on every cycle: the read position stays within its limit, a capture rewinds it, it stays frozen while the strobe is held, and the data output moves only on a read. They also check that the upper data bits stay clear and that the frame registers change only on an enabled tick. The bench scenarios are needed for the rest. Only they show the exact bit order across a whole sixteen-read sequence and the switch to a steady 1 afterwards. They also show that a repeated high strobe write leaves the earlier snapshot in place and that the adapter code appears only while the strobe is held.

// File: rtl/pad_reader_pkg.sv
`timescale 1ns/1ps
// Shared constants for the serial controller reader.
package pad_reader_pkg;
    localparam int unsigned PAD_BITS     = 16; // buttons per controller
    localparam int unsigned RD_DATA_W    = 8;  // processor data bus width
    localparam int unsigned PAD_PORTS    = 2;  // controller ports
    localparam int unsigned ADAPTER_CODE = 2;  // port 2 value while strobed with adapter
endpackage

// File: rtl/pad_shift_port.sv
`timescale 1ns/1ps
// One controller port: holds the snapshot taken at a strobe rise and returns
// one bit per read, MSB first, then a constant 1 once exhausted.
// Assumes: load is a single-cycle pulse; held_val uses only data bits 1..0.
module pad_shift_port #(
    parameter int unsigned BTN_W  = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned POS_W = $clog2(BTN_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              strobe_hi,
    input  logic              rd,
    input  logic [BTN_W-1:0]  word,
    input  logic [DATA_W-1:0] held_val,
    output logic [DATA_W-1:0] dout
);
    logic [BTN_W-1:0] shreg;
    logic [POS_W-1:0] pos;
    logic             done;

    assign done = (pos == POS_W'(BTN_W));

    // Snapshot on load, otherwise shift one bit per read while strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            pos   <= '0;
        end else if (load) begin
            shreg <= word;
            pos   <= '0;
        end else if (rd && !strobe_hi && !done) begin
            shreg <= shreg << 1;
            pos   <= pos + POS_W'(1);
        end
    end

    // Register the value returned by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (rd) begin
            if (strobe_hi)
                dout <= held_val;
            else if (done)
                dout <= DATA_W'(1);
            else
                dout <= DATA_W'(shreg[BTN_W-1]);
        end
    end

    AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_W'(BTN_W)); // R7
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pos == '0)); // R2
    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_hi && !load) |=> ($stable(pos) && $stable(shreg))); // R4
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(dout)); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dout[DATA_W-1:2] == '0); // R6
endmodule

// File: rtl/pad_frame_capture.sv
`timescale 1ns/1ps
// Parallel per-frame snapshot of all controller words.
// Assumes: tick is one cycle wide; enable is sampled with the tick.
module pad_frame_capture #(
    parameter int unsigned BTN_W = 16,
    parameter int unsigned PORTS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic                        tick,
    input  logic [PORTS-1:0][BTN_W-1:0] btn,
    output logic [PORTS-1:0][BTN_W-1:0] frame
);
    // Load every port's word on an enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame <= '0;
        else if (enable && tick)
            frame <= btn;
    end

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable && tick) |=> $stable(frame)); // R10
    AST_FRAME_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick) |=> (frame == $past(btn))); // R10
endmodule

// File: rtl/pad_serial_reader.sv
`timescale 1ns/1ps
// Top: shared strobe latch, one serial port per controller, frame capture.
// Assumes: only port index 1 (the second port) may report an adapter.
module pad_serial_reader
    import pad_reader_pkg::*;
#(
    parameter int unsigned BTN_W  = PAD_BITS,
    parameter int unsigned DATA_W = RD_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BTN_W-1:0]  pad1_buttons,
    input  logic [BTN_W-1:0]  pad2_buttons,
    input  logic              adapter_present,
    input  logic              strobe_we,
    input  logic [DATA_W-1:0] strobe_wdata,
    input  logic              pad1_rd,
    input  logic              pad2_rd,
    output logic [DATA_W-1:0] pad1_q,
    output logic [DATA_W-1:0] pad2_q,
    input  logic              auto_read_en,
    input  logic              frame_tick,
    output logic [BTN_W-1:0]  pad1_frame,
    output logic [BTN_W-1:0]  pad2_frame
);
    localparam int unsigned PORTS = PAD_PORTS;

    logic                         strobe_q;
    logic                         load;
    logic [PORTS-1:0][BTN_W-1:0]  btn;
    logic [PORTS-1:0][BTN_W-1:0]  frame;
    logic [PORTS-1:0]             rd;
    logic [PORTS-1:0][DATA_W-1:0] q;

    assign btn  = {pad2_buttons, pad1_buttons};
    assign rd   = {pad2_rd, pad1_rd};
    assign load = strobe_we && strobe_wdata[0] && !strobe_q;

    // Strobe latch follows bit 0 of each strobe write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= 1'b0;
        else if (strobe_we)
            strobe_q <= strobe_wdata[0];
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic [DATA_W-1:0] held;
        if (p == 1) begin : g_adapter
            assign held = adapter_present ? DATA_W'(ADAPTER_CODE) : '0;
        end else begin : g_plain
            assign held = '0;
        end
        pad_shift_port #(.BTN_W(BTN_W), .DATA_W(DATA_W)) u_port (
            .clk(clk), .rst_n(rst_n), .load(load), .strobe_hi(strobe_q),
            .rd(rd[p]), .word(btn[p]), .held_val(held), .dout(q[p])
        );
    end

    pad_frame_capture #(.BTN_W(BTN_W), .PORTS(PORTS)) u_frame (
        .clk(clk), .rst_n(rst_n), .enable(auto_read_en), .tick(frame_tick),
        .btn(btn), .frame(frame)
    );

    assign pad1_q     = q[0];
    assign pad2_q     = q[1];
    assign pad1_frame = frame[0];
    assign pad2_frame = frame[1];
endmodule

// File: tb/pad_serial_reader_test.sv
`timescale 1ns/1ps
module pad_serial_reader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] b1 = '0, b2 = '0;
    logic        adp = 1'b0;
    logic        swe = 1'b0;
    logic [7:0]  swd = '0;
    logic        r1 = 1'b0, r2 = 1'b0;
    logic [7:0]  q1, q2;
    logic        aen = 1'b0, tick = 1'b0;
    logic [15:0] f1, f2;

    int errs = 0, checks = 0;
    bit finished = 0;

    // bench model of the block's visible state
    logic [15:0] m_cap [2];
    int          m_pos [2];
    bit          m_lat = 0;

    always #5 clk = ~clk;

    pad_serial_reader uut (
        .clk(clk), .rst_n(rst_n), .pad1_buttons(b1), .pad2_buttons(b2),
        .adapter_present(adp), .strobe_we(swe), .strobe_wdata(swd),
        .pad1_rd(r1), .pad2_rd(r2), .pad1_q(q1), .pad2_q(q2),
        .auto_read_en(aen), .frame_tick(tick),
        .pad1_frame(f1), .pad2_frame(f2)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_read(input int p);
        logic [7:0] v;
        if (m_lat) v = (p == 1 && adp) ? 8'd2 : 8'd0;
        else if (m_pos[p] >= 16) v = 8'd1;
        else v = {7'd0, m_cap[p][15 - m_pos[p]]};
        return v;
    endfunction

    task automatic strobe(input logic [7:0] v);
        @(negedge clk); swe = 1'b1; swd = v;
        if (v[0] && !m_lat) begin
            m_cap[0] = b1; m_cap[1] = b2; m_pos[0] = 0; m_pos[1] = 0;
        end
        m_lat = v[0];
        @(negedge clk); swe = 1'b0;
    endtask

    task automatic rd_port(input int p, input string req);
        logic [7:0] e;
        e = expect_read(p);
        if (!m_lat && m_pos[p] < 16) m_pos[p]++;
        @(negedge clk);
        if (p == 0) r1 = 1'b1; else r2 = 1'b1;
        @(negedge clk);
        r1 = 1'b0; r2 = 1'b0;
        check(req, {8'd0, (p == 0) ? q1 : q2}, {8'd0, e});
    endtask

    initial begin
        m_cap[0] = '0; m_cap[1] = '0; m_pos[0] = 0; m_pos[1] = 0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad1_q", {8'd0, q1}, 16'd0);
        check("R1 pad2_q", {8'd0, q2}, 16'd0);
        check("R1 frame1", f1, 16'd0);
        check("R1 frame2", f2, 16'd0);

        // R2 R6 R7: full sequence then exhaustion
        b1 = 16'hA5C3; b2 = 16'h1234;
        strobe(8'h01); strobe(8'h00);
        b1 = 16'h0000; // live change after capture must not matter
        for (int i = 0; i < 16; i++) rd_port(0, "R6 serial order");
        for (int i = 0; i < 3; i++) rd_port(0, "R7 after sixteen");
        // R9: port 2 still at its first bit
        rd_port(1, "R9 independent position");
        // R8: output holds without reads
        repeat (3) @(negedge clk);
        check("R8 hold", {8'd0, q2}, {15'd0, 1'b0});

        // R4 R5 R3: strobe held
        b1 = 16'h8001; b2 = 16'hC000;
        strobe(8'h01);
        rd_port(0, "R4 held read");
        rd_port(0, "R4 held read");
        adp = 1'b1; rd_port(1, "R5 adapter code");
        adp = 1'b0; rd_port(1, "R5 no adapter");
        b1 = 16'h7FFE; b2 = 16'h3FFF;
        strobe(8'h03); // already high: no recapture (R3)
        strobe(8'h00);
        adp = 1'b1;
        rd_port(0, "R3 R4 first bit kept"); // expects 1 from 0x8001
        rd_port(1, "R11 adapter ignored");  // expects 1 from 0xC000
        rd_port(1, "R11 adapter ignored");
        rd_port(1, "R11 adapter ignored");  // expects 0
        adp = 1'b0;

        // R10 frame capture
        b1 = 16'hBEEF; b2 = 16'hCAFE;
        @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
        check("R10 disabled tick", f1, 16'd0);
        aen = 1'b1;
        @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
        check("R10 enabled tick p1", f1, 16'hBEEF);
        check("R10 enabled tick p2", f2, 16'hCAFE);
        b1 = 16'h1111;
        repeat (2) @(negedge clk);
        check("R10 hold between ticks", f1, 16'hBEEF);

        // random rounds
        for (int k = 0; k < 40; k++) begin
            b1 = 16'($urandom); b2 = 16'($urandom);
            adp = 1'($urandom);
            strobe(8'h01);
            if ($urandom % 3 == 0) rd_port($urandom % 2, "R4 R5 random held");
            strobe(8'h00);
            for (int j = 0; j < int'($urandom % 22); j++)
                rd_port($urandom % 2, "R6 R7 R9 random read");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule